// File: doc/BRIEF.md
# Interrupt Acceptance and Processor Status Flag Unit

This block keeps the processor status word and decides, every cycle, whether an interrupt is entered. Three kinds of request compete. A non-maskable line is caught on its rising edge. A software-interrupt strobe carries a 6-bit number. A maskable request carries a 3-bit priority and a 6-bit vector number. When one of them is taken, the unit clears the interrupt-enable flag and, where the rules call for it, forces the stack-select flag to the interrupt stack. For a maskable request it also raises the processor level to the request's priority. In the same clock edge it latches the pre-entry status word, so that a save sequence can push it, and the address of the vector-table entry.

The unit is built around a two-state controller. `ST_RUN` is the normal state, in which requests are arbitrated and ALU results and explicit writes update the flags. Transition `T_TAKE` leads from `ST_RUN` to `ST_ENTRY` when a request qualifies. `ST_ENTRY` lasts exactly one cycle, asserts the accept pulse and evaluates no new request. Transition `T_RESUME` then returns it to `ST_RUN`. Without a request the controller follows `T_IDLE`, which keeps it in `ST_RUN`. A 20-bit table base register is loaded through its own write strobe. The entry address is this base plus four times the vector number, truncated to 20 bits.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, flag_word, vec_addr and saved_flags are all zero, accept is low and the controller is in ST_RUN.
- R2: A maskable request is taken only when flag I is 1 and mi_prio is strictly greater than the 3-bit IPL field. accept rises in the cycle after the qualifying request is sampled and stays high for exactly one cycle.
- R3: In the accept cycle flag I reads 0, whatever kind of request was taken.
- R4: Taking a maskable request loads IPL with the request's priority. Taking a non-maskable or software interrupt leaves IPL unchanged.
- R5: Flag U is cleared when a non-maskable interrupt, a maskable interrupt, or a software interrupt numbered below 32 is taken. Software numbers 32 to 63 leave U unchanged. stack_sel equals U (0 = interrupt stack, 1 = user stack).
- R6: When upd_c is high, flag C loads alu_c. When upd_zso is high, flags Z, S and O load alu_z, alu_s and alu_o. flg_wr overrides both. In a cycle where a request is taken, neither ALU updates nor flg_wr have any effect.
- R7: flag_word layout: bit 0 C, bit 1 Z, bit 2 S, bit 3 O, bit 4 B, bit 5 U, bit 6 I, bit 7 D, bits 10:8 IPL. Bits 15:11 always read 0, even when written as 1.
- R8: bank_sel equals flag B (0 = bank 0, 1 = bank 1).
- R9: vec_addr is (table base + 4 × vector) mod 2^20. The vector is NMI_VECTOR (default 2) for the non-maskable interrupt, sw_num for software and mi_vec for maskable. The base used is the one held before any table write in the same cycle.
- R10: saved_flags holds the flag word as it was just before the entry update.
- R11: Priority is non-maskable over software over maskable. A request that loses arbitration is not taken in that cycle.
- R12: Requests are not evaluated in ST_ENTRY. A non-maskable rising edge seen there stays pending and is taken on the next ST_RUN cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mi_req | input | 1 | Maskable request (level) |
| mi_prio | input | 3 | Maskable request priority |
| mi_vec | input | 6 | Maskable request vector number |
| nmi_req | input | 1 | Non-maskable request (rising edge) |
| sw_stb | input | 1 | Software interrupt strobe |
| sw_num | input | 6 | Software interrupt number |
| alu_c | input | 1 | ALU carry/borrow/shift-out |
| alu_z | input | 1 | ALU result is zero |
| alu_s | input | 1 | ALU result is negative |
| alu_o | input | 1 | ALU result overflowed |
| upd_c | input | 1 | Load C from alu_c |
| upd_zso | input | 1 | Load Z, S, O from ALU |
| flg_wr | input | 1 | Write whole flag word |
| flg_wdata | input | 16 | Flag word write data |
| tbl_wr | input | 1 | Write table base register |
| tbl_wdata | input | 20 | Table base write data |
| flag_word | output | 16 | Current flag word |
| stack_sel | output | 1 | Stack pointer select (U flag) |
| bank_sel | output | 1 | Register bank select (B flag) |
| accept | output | 1 | One-cycle interrupt accept pulse |
| vec_addr | output | 20 | Vector-table entry address |
| saved_flags | output | 16 | Flag word captured before entry |

## Verification
The properties compare the flags in the accept cycle with `$past` samples of mi_prio, sw_num and the flag word. They therefore assume that these inputs are stable across the sampling edge and carry known values once reset is released. The bench drives every input on the falling clock edge and holds it through the following rising edge, so each sample is a single clean value. Random stimulus biases flag writes towards setting I, so that maskable acceptance, level blocking and the software stack rule are all reached many times.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    localparam int PRIO_W = 3;
    localparam int FLAG_W = 16;

    // Flag word, bit 0 is C.
    typedef struct packed {
        logic [4:0]        rsvd;
        logic [PRIO_W-1:0] ipl;
        logic              d;
        logic              i;
        logic              u;
        logic              b;
        logic              o;
        logic              s;
        logic              z;
        logic              c;
    } flag_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_SW   = 2'd2,
        SRC_MASK = 2'd3
    } src_t;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_ENTRY = 1'b1
    } state_t;

endpackage

// File: rtl/irq_nmi_catch.sv
module irq_nmi_catch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic clear,
    output logic pend
);
    logic nmi_q;
    logic pend_q;
    logic rise;

    assign rise = nmi_req & ~nmi_q;
    assign pend = pend_q | rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            nmi_q  <= nmi_req;
            pend_q <= pend & ~clear;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_flag_pkg::*;
#(
    parameter int VEC_W          = 6,
    parameter int NMI_VECTOR     = 2,
    parameter int SW_STACK_LIMIT = 32
) (
    input  logic              nmi_pend,
    input  logic              sw_stb,
    input  logic [VEC_W-1:0]  sw_num,
    input  logic              mi_req,
    input  logic [PRIO_W-1:0] mi_prio,
    input  logic [VEC_W-1:0]  mi_vec,
    input  logic              flag_i,
    input  logic [PRIO_W-1:0] flag_ipl,
    output logic              take,
    output src_t              src,
    output logic [VEC_W-1:0]  vec,
    output logic              sw_low
);
    logic mask_ok;

    assign mask_ok = mi_req && flag_i && (mi_prio > flag_ipl);
    assign sw_low  = int'(sw_num) < SW_STACK_LIMIT;

    always_comb begin
        src = SRC_NONE;
        vec = '0;
        if (nmi_pend) begin
            src = SRC_NMI;
            vec = VEC_W'(NMI_VECTOR);
        end else if (sw_stb) begin
            src = SRC_SW;
            vec = sw_num;
        end else if (mask_ok) begin
            src = SRC_MASK;
            vec = mi_vec;
        end
    end

    assign take = (src != SRC_NONE);
endmodule

// File: rtl/irq_vector_calc.sv
module irq_vector_calc #(
    parameter int VEC_W       = 6,
    parameter int ADDR_W      = 20,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] addr
);
    localparam int OFF_W = VEC_W + ENTRY_SHIFT;

    logic [ADDR_W-1:0] offset;

    generate
        if (OFF_W <= ADDR_W) begin : g_fit
            assign offset = ADDR_W'(vec) << ENTRY_SHIFT;
        end else begin : g_trunc
            logic [OFF_W-1:0] wide;
            assign wide   = OFF_W'(vec) << ENTRY_SHIFT;
            assign offset = wide[ADDR_W-1:0];
        end
    endgenerate

    assign addr = base + offset;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irq_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_en,
    input  src_t              entry_src,
    input  logic [PRIO_W-1:0] entry_prio,
    input  logic              entry_sw_low,
    input  logic              flg_wr,
    input  logic [FLAG_W-1:0] flg_wdata,
    input  logic              upd_c,
    input  logic              upd_zso,
    input  logic              alu_c,
    input  logic              alu_z,
    input  logic              alu_s,
    input  logic              alu_o,
    output flag_t             flags
);
    flag_t wr_word;
    flag_t nxt;

    always_comb begin
        wr_word      = flag_t'(flg_wdata);
        wr_word.rsvd = '0;
    end

    always_comb begin
        nxt = flags;
        if (entry_en) begin
            nxt.i = 1'b0;
            if (entry_src != SRC_SW || entry_sw_low) begin
                nxt.u = 1'b0;
            end
            if (entry_src == SRC_MASK) begin
                nxt.ipl = entry_prio;
            end
        end else if (flg_wr) begin
            nxt = wr_word;
        end else begin
            if (upd_c) begin
                nxt.c = alu_c;
            end
            if (upd_zso) begin
                nxt.z = alu_z;
                nxt.s = alu_s;
                nxt.o = alu_o;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= nxt;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flg_wr && !entry_en |=> flags.rsvd == '0); // R7
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irq_flag_pkg::*;
#(
    parameter int VEC_W          = 6,
    parameter int ADDR_W         = 20,
    parameter int ENTRY_SHIFT    = 2,
    parameter int NMI_VECTOR     = 2,
    parameter int SW_STACK_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mi_req,
    input  logic [2:0]        mi_prio,
    input  logic [VEC_W-1:0]  mi_vec,
    input  logic              nmi_req,
    input  logic              sw_stb,
    input  logic [VEC_W-1:0]  sw_num,
    input  logic              alu_c,
    input  logic              alu_z,
    input  logic              alu_s,
    input  logic              alu_o,
    input  logic              upd_c,
    input  logic              upd_zso,
    input  logic              flg_wr,
    input  logic [15:0]       flg_wdata,
    input  logic              tbl_wr,
    input  logic [ADDR_W-1:0] tbl_wdata,
    output logic [15:0]       flag_word,
    output logic              stack_sel,
    output logic              bank_sel,
    output logic              accept,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [15:0]       saved_flags
);
    state_t            state_q;
    state_t            state_d;
    flag_t             flags;
    logic              nmi_pend;
    logic              take;
    logic              take_run;
    src_t              src;
    src_t              acc_src_q;
    logic [VEC_W-1:0]  vec;
    logic              sw_low;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] entry_addr;

    irq_nmi_catch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_req (nmi_req),
        .clear   (take_run && src == SRC_NMI),
        .pend    (nmi_pend)
    );

    irq_arbiter #(
        .VEC_W          (VEC_W),
        .NMI_VECTOR     (NMI_VECTOR),
        .SW_STACK_LIMIT (SW_STACK_LIMIT)
    ) u_arb (
        .nmi_pend (nmi_pend),
        .sw_stb   (sw_stb),
        .sw_num   (sw_num),
        .mi_req   (mi_req),
        .mi_prio  (mi_prio),
        .mi_vec   (mi_vec),
        .flag_i   (flags.i),
        .flag_ipl (flags.ipl),
        .take     (take),
        .src      (src),
        .vec      (vec),
        .sw_low   (sw_low)
    );

    irq_vector_calc #(
        .VEC_W       (VEC_W),
        .ADDR_W      (ADDR_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_vec (
        .base (base_q),
        .vec  (vec),
        .addr (entry_addr)
    );

    irq_flag_reg u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .entry_en     (take_run),
        .entry_src    (src),
        .entry_prio   (mi_prio),
        .entry_sw_low (sw_low),
        .flg_wr       (flg_wr),
        .flg_wdata    (flg_wdata),
        .upd_c        (upd_c),
        .upd_zso      (upd_zso),
        .alu_c        (alu_c),
        .alu_z        (alu_z),
        .alu_s        (alu_s),
        .alu_o        (alu_o),
        .flags        (flags)
    );

    assign take_run = take && (state_q == ST_RUN);

    // Next state: T_IDLE, T_TAKE, T_RESUME
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = take ? ST_ENTRY : ST_RUN;
            ST_ENTRY: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and table base
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_addr    <= '0;
            saved_flags <= '0;
            acc_src_q   <= SRC_NONE;
            base_q      <= '0;
        end else begin
            if (take_run) begin
                vec_addr    <= entry_addr;
                saved_flags <= flags;
                acc_src_q   <= src;
            end
            if (tbl_wr) begin
                base_q <= tbl_wdata;
            end
        end
    end

    assign accept    = (state_q == ST_ENTRY);
    assign flag_word = flags;
    assign stack_sel = flags.u;
    assign bank_sel  = flags.b;

    AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept); // R2

    AST_ACCEPT_CLEARS_I: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !flags.i); // R3

    AST_MASK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        accept && acc_src_q == SRC_MASK |->
            flags.ipl == $past(mi_prio) && $past(flags.i)
            && ($past(mi_prio) > $past(flags.ipl))); // R4

    AST_SW_HIGH_KEEPS_U: assert property (@(posedge clk) disable iff (!rst_n)
        accept && acc_src_q == SRC_SW && int'($past(sw_num)) >= SW_STACK_LIMIT
            |-> flags.u == $past(flags.u)); // R5

    AST_SAVED_PRE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> saved_flags == $past(flag_word)); // R10

    AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        accept && acc_src_q != SRC_NMI |-> !$past(nmi_pend)); // R11
endmodule

// File: tb/irq_flag_unit_test.sv
`timescale 1ns/1ps
module irq_flag_unit_test;
    localparam int NMIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mi_req = 0, nmi_req = 0, sw_stb = 0;
    logic [2:0]  mi_prio = 0;
    logic [5:0]  mi_vec = 0, sw_num = 0;
    logic        alu_c = 0, alu_z = 0, alu_s = 0, alu_o = 0, upd_c = 0, upd_zso = 0;
    logic        flg_wr = 0, tbl_wr = 0;
    logic [15:0] flg_wdata = 0;
    logic [19:0] tbl_wdata = 0;
    logic [15:0] flag_word, saved_flags;
    logic        stack_sel, bank_sel, accept;
    logic [19:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    irq_flag_unit #(.NMI_VECTOR(NMIV)) uut (
        .clk(clk), .rst_n(rst_n), .mi_req(mi_req), .mi_prio(mi_prio), .mi_vec(mi_vec),
        .nmi_req(nmi_req), .sw_stb(sw_stb), .sw_num(sw_num),
        .alu_c(alu_c), .alu_z(alu_z), .alu_s(alu_s), .alu_o(alu_o),
        .upd_c(upd_c), .upd_zso(upd_zso), .flg_wr(flg_wr), .flg_wdata(flg_wdata),
        .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata), .flag_word(flag_word),
        .stack_sel(stack_sel), .bank_sel(bank_sel), .accept(accept),
        .vec_addr(vec_addr), .saved_flags(saved_flags)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [15:0] m_flags, m_saved;
    logic [19:0] m_base, m_vec;
    bit          m_busy, m_pend, m_nmiq;

    always @(posedge clk) begin
        bit rise, np, mq, took;
        int v;
        if (!rst_n) begin
            m_flags = 0; m_saved = 0; m_base = 0; m_vec = 0;
            m_busy = 0; m_pend = 0; m_nmiq = 0;
        end else begin
            rise = nmi_req && !m_nmiq;
            m_nmiq = nmi_req;
            took = 0;
            if (m_busy) begin
                m_busy = 0;
                m_pend = m_pend | rise;
            end else begin
                np = m_pend | rise;
                mq = mi_req && m_flags[6] && (mi_prio > m_flags[10:8]);
                if (np || sw_stb || mq) begin
                    took = 1;
                    m_saved = m_flags;
                    if (np) begin
                        v = NMIV; m_flags[5] = 0;
                    end else if (sw_stb) begin
                        v = sw_num; if (sw_num < 32) m_flags[5] = 0;
                    end else begin
                        v = mi_vec; m_flags[5] = 0; m_flags[10:8] = mi_prio;
                    end
                    m_flags[6] = 0;
                    m_vec = 20'(int'(m_base) + v * 4);
                    m_busy = 1;
                    m_pend = 0;
                end else begin
                    m_pend = np;
                end
            end
            if (!took) begin
                if (flg_wr) m_flags = flg_wdata & 16'h07FF;
                else begin
                    if (upd_c) m_flags[0] = alu_c;
                    if (upd_zso) begin
                        m_flags[1] = alu_z; m_flags[2] = alu_s; m_flags[3] = alu_o;
                    end
                end
            end
            if (tbl_wr) m_base = tbl_wdata;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 accept", accept, m_busy);
            chk("R6 flag_word", flag_word, m_flags);
            chk("R5 stack_sel", stack_sel, m_flags[5]);
            chk("R8 bank_sel", bank_sel, m_flags[4]);
            chk("R9 vec_addr", vec_addr, m_vec);
            chk("R10 saved_flags", saved_flags, m_saved);
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_flags(input logic [15:0] d);
        flg_wr = 1; flg_wdata = d; step(); flg_wr = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); step(); step();
        rst_n = 1;
        step();
        chk("R1 reset flags", flag_word, 16'h0000);
        chk("R1 reset accept", accept, 1'b0);
        chk("R1 reset vec", vec_addr, 20'h0);

        wr_flags(16'hFA70);
        chk("R7 reserved masked", flag_word, 16'h0270);
        chk("R8 bank one", bank_sel, 1'b1);
        tbl_wr = 1; tbl_wdata = 20'h12340; step(); tbl_wr = 0;

        mi_req = 1; mi_prio = 3'd2; mi_vec = 6'd5;
        step(); step();
        chk("R2 equal level blocked", accept, 1'b0);
        mi_prio = 3'd5;
        step();
        chk("R2 accepted", accept, 1'b1);
        chk("R3 I cleared", flag_word[6], 1'b0);
        chk("R4 IPL loaded", flag_word, 16'h0510);
        chk("R9 mask vector", vec_addr, 20'h12354);
        chk("R10 saved", saved_flags, 16'h0270);
        mi_req = 0;
        step();
        chk("R2 single pulse", accept, 1'b0);

        wr_flags(16'h0360);
        sw_stb = 1; sw_num = 6'd40; step(); sw_stb = 0;
        chk("R5 high sw keeps U", flag_word, 16'h0320);
        chk("R9 sw vector", vec_addr, 20'h123E0);
        step();
        sw_stb = 1; sw_num = 6'd10; step(); sw_stb = 0;
        chk("R5 low sw clears U", flag_word, 16'h0300);
        chk("R4 sw keeps IPL", flag_word[10:8], 3'd3);
        step();

        wr_flags(16'h0060);
        nmi_req = 1; sw_stb = 1; sw_num = 6'd20; mi_req = 1; mi_prio = 3'd7; mi_vec = 6'd3;
        step();
        sw_stb = 0; mi_req = 0;
        chk("R11 nmi wins", vec_addr, 20'h12348);
        chk("R11 nmi flags", flag_word, 16'h0000);
        step();
        chk("R11 loser not taken", accept, 1'b0);

        nmi_req = 0; sw_stb = 1; sw_num = 6'd33;
        step();
        chk("R12 sw entry", accept, 1'b1);
        sw_stb = 0; nmi_req = 1;
        step();
        chk("R12 not taken in entry", accept, 1'b0);
        step();
        chk("R12 pending nmi taken", accept, 1'b1);
        chk("R12 nmi vector", vec_addr, 20'h12348);
        step();

        for (int k = 0; k < 3000; k++) begin
            mi_req  = ($urandom % 3) == 0;
            mi_prio = 3'($urandom);
            mi_vec  = 6'($urandom);
            sw_stb  = ($urandom % 30) == 0;
            sw_num  = 6'($urandom);
            if (($urandom % 40) == 0) nmi_req = ~nmi_req;
            {alu_c, alu_z, alu_s, alu_o, upd_c, upd_zso} = 6'($urandom);
            flg_wr    = ($urandom % 8) == 0;
            flg_wdata = 16'($urandom) | (($urandom % 4 != 0) ? 16'h0040 : 16'h0000);
            tbl_wr    = ($urandom % 50) == 0;
            tbl_wdata = 20'($urandom);
            step();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule